// File: doc/BRIEF.md
# Packet-Driven Register Bus Master

This block lives inside a slave device, downstream of a de-framing stage. It receives request packets as a byte stream whose first and last bytes carry start and end markers. The first eight bytes of each packet form a fixed request header. The block decodes that header, checks that the packet length agrees with it, and then runs 32-bit read or write accesses on a simple memory-mapped master port that has a wait-request input. A request is either a single access or a sequential burst. Every packet that passes its checks produces one response packet on an output byte stream.

The two response formats differ. A write response is a four-byte header that echoes the opcode with its top bit set and reports how many bytes were written. A read response carries only the read data, with no header. Write data is held in an internal buffer until the end of the packet has been checked. A malformed packet therefore leaves no trace on the bus.

Top module: `tl_bus_master`

## Requirements
- R1: A request header is, in order: opcode, reserved byte, 16-bit byte count (high byte first), and 32-bit address (most significant byte first). Opcode 0x00 with count 4, followed by one data word sent least significant byte first, writes that word to the address.
- R2: Every accepted write produces exactly one 4-byte response packet. Its bytes are, in order: opcode OR 0x80, 0x00, count high byte, count low byte. The start marker is on the first byte and the end marker on the last.
- R3: Opcode 0x10 with count 4 reads one word. The response packet is the 4 data bytes, least significant byte first, with no header, marked as start on the first byte and end on the last.
- R4: Opcode 0x14 reads count/4 words, where count is a nonzero multiple of 4 and at most 1024 (256 words). Addresses start at the header address and step by 4. All the words are returned in one packet, in address order.
- R5: Opcode 0x04 writes count/4 data words, at most MAX_WR_WORDS of them (default 4), to addresses that step by 4. The response reports the full byte count.
- R6: While wait request is high, address, read strobe, write strobe and write data stay unchanged. Read and write strobes are never high together.
- R7: A packet whose total length does not equal 8 bytes for a read, or 8 + count bytes for a write, is discarded. So is a packet whose count is illegal for its opcode. A discarded packet causes no bus access and no output.
- R8: A packet with any opcode other than 0x00, 0x04, 0x10, 0x14 or 0x7F is discarded without a bus access or an output.
- R9: Opcode 0x7F in an 8-byte packet causes no bus access. Its response is the 4 bytes 0xFF, 0x00, 0x00, 0x00.
- R10: Bytes that arrive outside a packet are ignored. A start marker in the middle of a packet abandons the partial packet and begins a new one.
- R11: Input ready is low from the cycle after a valid packet's last byte until its response has been fully emitted.
- R12: After reset the output stream is idle, no bus strobe is active and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request byte valid |
| in_ready_o | output | 1 | Block can accept a request byte |
| in_data_i | input | 8 | Request byte |
| in_sop_i | input | 1 | First byte of a request packet |
| in_eop_i | input | 1 | Last byte of a request packet |
| out_valid_o | output | 1 | Response byte valid |
| out_data_o | output | 8 | Response byte |
| out_sop_o | output | 1 | First byte of a response packet |
| out_eop_o | output | 1 | Last byte of a response packet |
| bus_addr_o | output | 32 | Bus byte address |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data, taken when wait request is low |
| bus_wait_i | input | 1 | Wait request; stretches the current access |

## Verification
The assertions check four things on every cycle. Commands are held stable under wait request. Read and write strobes never overlap. The decoder raises a command only when the engine is idle and only for one cycle. The response serializer is never loaded while it is still emitting. The bench scenarios cover the rest: the byte ordering of headers, data and responses, the stepping of addresses in bursts, the 256-word read, and the discard rules for bad length, bad count and unknown opcode. Discards can only be seen there by an unchanged access count, unchanged memory and the absence of any output.

// File: rtl/tl_pkg.sv
`timescale 1ns/1ps
package tl_pkg;
  localparam logic [7:0] OP_WR  = 8'h00;
  localparam logic [7:0] OP_SWR = 8'h04;
  localparam logic [7:0] OP_RD  = 8'h10;
  localparam logic [7:0] OP_SRD = 8'h14;
  localparam logic [7:0] OP_NOP = 8'h7F;
  localparam logic [7:0] RESP_FLAG = 8'h80;
endpackage

// File: rtl/tl_req_parser.sv
`timescale 1ns/1ps
module tl_req_parser import tl_pkg::*; #(
  parameter int MAX_WR_WORDS = 4,
  parameter int MAX_RD_WORDS = 256,
  parameter int WW  = $clog2(MAX_RD_WORDS + 1),
  parameter int WIW = (MAX_WR_WORDS > 1) ? $clog2(MAX_WR_WORDS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         acc_i,
  input  logic [7:0]                   data_i,
  input  logic                         sop_i,
  input  logic                         eop_i,
  output logic                         cmd_valid_o,
  output logic [7:0]                   cmd_op_o,
  output logic [15:0]                  cmd_cnt_o,
  output logic [WW-1:0]                cmd_words_o,
  output logic [31:0]                  cmd_addr_o,
  output logic [MAX_WR_WORDS-1:0][31:0] wbuf_o
);
  localparam logic [13:0] MAXW = 14'(MAX_WR_WORDS);
  localparam logic [13:0] MAXR = 14'(MAX_RD_WORDS);

  logic        in_pkt_q, cmd_valid_q;
  logic [15:0] idx_q, cnt_q, dofs;
  logic [7:0]  op_q;
  logic [31:0] addr_q;
  logic [MAX_WR_WORDS-1:0][31:0] wbuf_q;
  logic [13:0] wsel, words;
  logic [1:0]  lane;
  logic        len_wr_ok, hdr_end, cnt_shape, pkt_ok;

  assign dofs  = idx_q - 16'd8;
  assign wsel  = dofs[15:2];
  assign lane  = dofs[1:0];
  assign words = cnt_q[15:2];

  always_comb begin
    len_wr_ok = ({1'b0, idx_q} == ({1'b0, cnt_q} + 17'd7));
    hdr_end   = (idx_q == 16'd7);
    cnt_shape = (cnt_q[1:0] == 2'b00) && (cnt_q != 16'd0);
    case (op_q)
      OP_WR:   pkt_ok = (cnt_q == 16'd4) && len_wr_ok;
      OP_SWR:  pkt_ok = cnt_shape && (words <= MAXW) && len_wr_ok;
      OP_RD:   pkt_ok = (cnt_q == 16'd4) && hdr_end;
      OP_SRD:  pkt_ok = cnt_shape && (words <= MAXR) && hdr_end;
      OP_NOP:  pkt_ok = hdr_end;
      default: pkt_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q    <= 1'b0;
      cmd_valid_q <= 1'b0;
      idx_q       <= '0;
      cnt_q       <= '0;
      op_q        <= '0;
      addr_q      <= '0;
      wbuf_q      <= '0;
    end else begin
      cmd_valid_q <= 1'b0;
      if (acc_i) begin
        if (sop_i) begin
          in_pkt_q <= ~eop_i;
          idx_q    <= 16'd1;
          op_q     <= data_i;
        end else if (in_pkt_q) begin
          if (idx_q != 16'hFFFF) idx_q <= idx_q + 16'd1;
          case (idx_q)
            16'd2: cnt_q[15:8]   <= data_i;
            16'd3: cnt_q[7:0]    <= data_i;
            16'd4: addr_q[31:24] <= data_i;
            16'd5: addr_q[23:16] <= data_i;
            16'd6: addr_q[15:8]  <= data_i;
            16'd7: addr_q[7:0]   <= data_i;
            default:
              if (idx_q >= 16'd8 && wsel < MAXW)
                wbuf_q[wsel[WIW-1:0]][{lane, 3'b000} +: 8] <= data_i;
          endcase
          if (eop_i) begin
            in_pkt_q    <= 1'b0;
            cmd_valid_q <= pkt_ok;
          end
        end
      end
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = op_q;
  assign cmd_cnt_o   = cnt_q;
  assign cmd_words_o = cnt_q[WW+1:2];
  assign cmd_addr_o  = addr_q;
  assign wbuf_o      = wbuf_q;

  // R11: input is closed after a command, so no back-to-back command
  p_cmd_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: rtl/tl_bus_engine.sv
`timescale 1ns/1ps
module tl_bus_engine import tl_pkg::*; #(
  parameter int MAX_WR_WORDS = 4,
  parameter int WW  = 9,
  parameter int WIW = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  input  logic [7:0]                    cmd_op_i,
  input  logic [15:0]                   cmd_cnt_i,
  input  logic [WW-1:0]                 cmd_words_i,
  input  logic [31:0]                   cmd_addr_i,
  input  logic [MAX_WR_WORDS-1:0][31:0] wbuf_i,
  output logic [31:0]                   bus_addr_o,
  output logic                          bus_rd_o,
  output logic                          bus_wr_o,
  output logic [31:0]                   bus_wdata_o,
  input  logic [31:0]                   bus_rdata_i,
  input  logic                          bus_wait_i,
  output logic                          fr_load_o,
  output logic [31:0]                   fr_word_o,
  output logic                          fr_sop_o,
  output logic                          fr_eop_o,
  input  logic                          fr_busy_i,
  output logic                          busy_o
);
  typedef enum logic [2:0] {S_IDLE, S_ACC, S_DRAIN, S_RESP, S_FIN} eng_state_e;

  eng_state_e   state_q;
  logic [7:0]   op_q;
  logic [15:0]  cnt_q, resp_cnt;
  logic [WW-1:0] idx_q, last_q;
  logic [31:0]  addr_q;
  logic         is_rd, at_last, done_acc;

  assign is_rd    = (op_q == OP_RD) || (op_q == OP_SRD);
  assign at_last  = (idx_q == last_q);
  assign done_acc = (state_q == S_ACC) && !bus_wait_i;
  assign resp_cnt = (op_q == OP_NOP) ? 16'd0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE:
          if (cmd_valid_i) begin
            op_q    <= cmd_op_i;
            cnt_q   <= cmd_cnt_i;
            last_q  <= cmd_words_i - 1'b1;
            addr_q  <= cmd_addr_i;
            idx_q   <= '0;
            state_q <= (cmd_op_i == OP_NOP) ? S_RESP : S_ACC;
          end
        S_ACC:
          if (!bus_wait_i) begin
            if (is_rd) state_q <= S_DRAIN;
            else if (at_last) state_q <= S_RESP;
            else begin
              idx_q  <= idx_q + 1'b1;
              addr_q <= addr_q + 32'd4;
            end
          end
        S_DRAIN:
          if (!fr_busy_i) begin
            if (at_last) state_q <= S_IDLE;
            else begin
              idx_q   <= idx_q + 1'b1;
              addr_q  <= addr_q + 32'd4;
              state_q <= S_ACC;
            end
          end
        S_RESP:  state_q <= S_FIN;
        S_FIN:   if (!fr_busy_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bus_addr_o  = addr_q;
  assign bus_rd_o    = (state_q == S_ACC) && is_rd;
  assign bus_wr_o    = (state_q == S_ACC) && !is_rd;
  assign bus_wdata_o = wbuf_i[idx_q[WIW-1:0]];

  assign fr_load_o = (done_acc && is_rd) || (state_q == S_RESP);
  assign fr_word_o = (state_q == S_RESP)
                   ? {resp_cnt[7:0], resp_cnt[15:8], 8'h00, op_q | RESP_FLAG}
                   : bus_rdata_i;
  assign fr_sop_o  = (state_q == S_RESP) || (idx_q == '0);
  assign fr_eop_o  = (state_q == S_RESP) || at_last;
  assign busy_o    = (state_q != S_IDLE);

  // R6: command held while the bus stretches the access
  p_hold_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) && bus_wait_i |=>
      $stable(bus_addr_o) && $stable(bus_rd_o) && $stable(bus_wr_o) && $stable(bus_wdata_o));
  // R6: strobes exclusive
  p_excl_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));
  // R11: decoder only issues into an idle engine
  p_cmd_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> (state_q == S_IDLE));
endmodule

// File: rtl/tl_resp_framer.sv
`timescale 1ns/1ps
module tl_resp_framer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic        sop_i,
  input  logic        eop_i,
  output logic        busy_o,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_sop_o,
  output logic        out_eop_o
);
  logic        active_q, sop_q, eop_q;
  logic [1:0]  lane_q;
  logic [31:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sop_q    <= 1'b0;
      eop_q    <= 1'b0;
      lane_q   <= '0;
      word_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      lane_q   <= '0;
      word_q   <= word_i;
      sop_q    <= sop_i;
      eop_q    <= eop_i;
    end else if (active_q) begin
      if (lane_q == 2'd3) active_q <= 1'b0;
      lane_q <= lane_q + 2'd1;
    end
  end

  assign busy_o      = active_q;
  assign out_valid_o = active_q;
  assign out_data_o  = word_q[{lane_q, 3'b000} +: 8];
  assign out_sop_o   = active_q && sop_q && (lane_q == 2'd0);
  assign out_eop_o   = active_q && eop_q && (lane_q == 2'd3);

  // R4: a word is never overwritten while being emitted
  p_no_overrun_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !active_q);
endmodule

// File: rtl/tl_bus_master.sv
`timescale 1ns/1ps
module tl_bus_master #(
  parameter int MAX_WR_WORDS = 4,
  parameter int MAX_RD_WORDS = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [7:0]  in_data_i,
  input  logic        in_sop_i,
  input  logic        in_eop_i,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_sop_o,
  output logic        out_eop_o,
  output logic [31:0] bus_addr_o,
  output logic        bus_rd_o,
  output logic        bus_wr_o,
  output logic [31:0] bus_wdata_o,
  input  logic [31:0] bus_rdata_i,
  input  logic        bus_wait_i
);
  localparam int WW  = $clog2(MAX_RD_WORDS + 1);
  localparam int WIW = (MAX_WR_WORDS > 1) ? $clog2(MAX_WR_WORDS) : 1;

  logic                          cmd_valid, eng_busy, fr_load, fr_sop, fr_eop, fr_busy;
  logic [7:0]                    cmd_op;
  logic [15:0]                   cmd_cnt;
  logic [WW-1:0]                 cmd_words;
  logic [31:0]                   cmd_addr, fr_word;
  logic [MAX_WR_WORDS-1:0][31:0] wbuf;

  assign in_ready_o = !cmd_valid && !eng_busy;

  tl_req_parser #(
    .MAX_WR_WORDS(MAX_WR_WORDS), .MAX_RD_WORDS(MAX_RD_WORDS), .WW(WW), .WIW(WIW)
  ) u_parser (
    .clk_i, .rst_ni,
    .acc_i(in_valid_i && in_ready_o),
    .data_i(in_data_i), .sop_i(in_sop_i), .eop_i(in_eop_i),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_cnt_o(cmd_cnt),
    .cmd_words_o(cmd_words), .cmd_addr_o(cmd_addr), .wbuf_o(wbuf)
  );

  tl_bus_engine #(.MAX_WR_WORDS(MAX_WR_WORDS), .WW(WW), .WIW(WIW)) u_engine (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_cnt_i(cmd_cnt),
    .cmd_words_i(cmd_words), .cmd_addr_i(cmd_addr), .wbuf_i(wbuf),
    .bus_addr_o, .bus_rd_o, .bus_wr_o, .bus_wdata_o, .bus_rdata_i, .bus_wait_i,
    .fr_load_o(fr_load), .fr_word_o(fr_word), .fr_sop_o(fr_sop), .fr_eop_o(fr_eop),
    .fr_busy_i(fr_busy), .busy_o(eng_busy)
  );

  tl_resp_framer u_framer (
    .clk_i, .rst_ni,
    .load_i(fr_load), .word_i(fr_word), .sop_i(fr_sop), .eop_i(fr_eop),
    .busy_o(fr_busy),
    .out_valid_o, .out_data_o, .out_sop_o, .out_eop_o
  );
endmodule

// File: tb/tl_bus_master_tb_top.sv
`timescale 1ns/1ps
module tl_bus_master_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_sop_i = 1'b0, in_eop_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ready_o, out_valid_o, out_sop_o, out_eop_o;
  logic [7:0]  out_data_o;
  logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic        bus_rd_o, bus_wr_o, bus_wait_i;
  logic        wait_en = 1'b0;
  logic [7:0]  lfsr;
  logic [31:0] mem [64];
  int          acc_cnt;

  int checks = 0, errors = 0;
  logic [9:0]  exp_q [$];
  string       tag_q [$];
  logic [7:0]  tx_q [$];
  logic [31:0] ref_m [64];
  string       cur_tag = "R12";

  always #10 clk_i = ~clk_i;

  tl_bus_master dut_i (.*);

  function automatic logic [31:0] seed_val(int i);
    return 32'h1F2E3D4C ^ (32'(i) * 32'h00010203);
  endfunction

  // bus slave model
  assign bus_wait_i  = wait_en & lfsr[0];
  assign bus_rdata_i = mem[bus_addr_o[7:2]];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr    <= 8'hA5;
      acc_cnt <= 0;
      for (int i = 0; i < 64; i++) mem[i] <= seed_val(i);
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if ((bus_rd_o || bus_wr_o) && !bus_wait_i) acc_cnt <= acc_cnt + 1;
      if (bus_wr_o && !bus_wait_i) mem[bus_addr_o[7:2]] <= bus_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (exp_q.size() == 0)
        chk(1'b0, {cur_tag, " unexpected output"}, {22'd0, out_sop_o, out_eop_o, out_data_o}, 32'h0);
      else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_sop_o, out_eop_o, out_data_o} == e, t,
            {22'd0, out_sop_o, out_eop_o, out_data_o}, {22'd0, e});
      end
    end
  end

  task automatic exp_word(input logic [31:0] w, input bit s, input bit e, input string t);
    for (int b = 0; b < 4; b++) begin
      exp_q.push_back({s && b == 0, e && b == 3, w[8*b +: 8]});
      tag_q.push_back(t);
    end
  endtask

  task automatic exp_resp(input logic [7:0] op, input logic [15:0] cnt, input string t);
    exp_word({cnt[7:0], cnt[15:8], 8'h00, op | 8'h80}, 1'b1, 1'b1, t);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [15:0] cnt, input logic [31:0] a);
    tx_q.push_back(op); tx_q.push_back(8'h00);
    tx_q.push_back(cnt[15:8]); tx_q.push_back(cnt[7:0]);
    tx_q.push_back(a[31:24]); tx_q.push_back(a[23:16]);
    tx_q.push_back(a[15:8]); tx_q.push_back(a[7:0]);
  endtask

  task automatic put_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) tx_q.push_back(w[8*b +: 8]);
  endtask

  task automatic send_raw(input logic [7:0] d, input bit s, input bit e);
    in_valid_i = 1'b1; in_data_i = d; in_sop_i = s; in_eop_i = e;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0;
  endtask

  task automatic send_pkt();
    int n;
    n = tx_q.size();
    for (int i = 0; i < n; i++) send_raw(tx_q[i], i == 0, i == n - 1);
    tx_q.delete();
  endtask

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      if (exp_q.size() == 0 && in_ready_o) break;
      @(negedge clk_i);
    end
    repeat (6) @(negedge clk_i);
    chk(exp_q.size() == 0, {cur_tag, " response incomplete"}, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic run_all();
    int a0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 64; i++) ref_m[i] = seed_val(i);
    @(negedge clk_i);
    chk(!out_valid_o && !bus_rd_o && !bus_wr_o && in_ready_o, "R12 reset state",
        {28'd0, out_valid_o, bus_rd_o, bus_wr_o, in_ready_o}, 32'd1);

    // R1/R2 single write
    cur_tag = "R2";
    a0 = acc_cnt;
    exp_resp(8'h00, 16'd4, "R2 write response");
    hdr(8'h00, 16'd4, 32'h0000_0010); put_word(32'hA1B2_C37D);
    send_pkt();
    chk(!in_ready_o, "R11 ready low after packet", {31'd0, in_ready_o}, 32'd0);
    drain();
    ref_m[4] = 32'hA1B2_C37D;
    chk(mem[4] == ref_m[4], "R1 single write data", mem[4], ref_m[4]);
    chk(acc_cnt == a0 + 1, "R1 one access", 32'(acc_cnt - a0), 32'd1);

    // R3 single read
    cur_tag = "R3";
    exp_word(ref_m[4], 1'b1, 1'b1, "R3 single read data");
    hdr(8'h10, 16'd4, 32'h0000_0010);
    send_pkt();
    drain();

    // R5 sequential write of 4 words
    cur_tag = "R5";
    a0 = acc_cnt;
    exp_resp(8'h04, 16'd16, "R5 burst write response");
    hdr(8'h04, 16'd16, 32'h0000_0040);
    for (int k = 0; k < 4; k++) put_word(32'hC0DE_0000 + 32'(k * 17));
    send_pkt();
    drain();
    for (int k = 0; k < 4; k++) begin
      ref_m[16 + k] = 32'hC0DE_0000 + 32'(k * 17);
      chk(mem[16 + k] == ref_m[16 + k], "R5 burst write word", mem[16 + k], ref_m[16 + k]);
    end
    chk(acc_cnt == a0 + 4, "R5 burst access count", 32'(acc_cnt - a0), 32'd4);

    // R4/R6 sequential read under wait request
    cur_tag = "R6";
    wait_en = 1'b1;
    for (int k = 0; k < 3; k++) exp_word(ref_m[17 + k], k == 0, k == 2, "R6 read under wait");
    hdr(8'h14, 16'd12, 32'h0000_0044);
    send_pkt();
    drain();
    wait_en = 1'b0;

    // R4 maximum read of 256 words
    cur_tag = "R4";
    a0 = acc_cnt;
    for (int k = 0; k < 256; k++) exp_word(ref_m[k & 63], k == 0, k == 255, "R4 long read");
    hdr(8'h14, 16'h0400, 32'h0000_0000);
    send_pkt();
    drain();
    chk(acc_cnt == a0 + 256, "R4 long read access count", 32'(acc_cnt - a0), 32'd256);

    // R7 discards: short write, oversized burst write, long read
    cur_tag = "R7";
    a0 = acc_cnt;
    hdr(8'h00, 16'd4, 32'h0000_0020); tx_q.push_back(8'h11); tx_q.push_back(8'h22); tx_q.push_back(8'h33);
    send_pkt();
    chk(in_ready_o, "R7 short write not executed", {31'd0, in_ready_o}, 32'd1);
    hdr(8'h04, 16'd20, 32'h0000_0020);
    for (int k = 0; k < 5; k++) put_word(32'hDEAD_0000 + 32'(k));
    send_pkt();
    hdr(8'h10, 16'd4, 32'h0000_0020); tx_q.push_back(8'h00);
    send_pkt();
    hdr(8'h14, 16'd6, 32'h0000_0020);
    send_pkt();
    repeat (30) @(negedge clk_i);
    chk(acc_cnt == a0, "R7 no bus access", 32'(acc_cnt - a0), 32'd0);
    chk(mem[8] == ref_m[8], "R7 memory untouched", mem[8], ref_m[8]);

    // R8 unknown opcode
    cur_tag = "R8";
    hdr(8'h22, 16'd4, 32'h0000_0020);
    send_pkt();
    repeat (30) @(negedge clk_i);
    chk(acc_cnt == a0, "R8 unknown opcode no access", 32'(acc_cnt - a0), 32'd0);

    // R9 no-transaction
    cur_tag = "R9";
    exp_word(32'h0000_00FF, 1'b1, 1'b1, "R9 no-transaction response");
    hdr(8'h7F, 16'd0, 32'h0);
    send_pkt();
    drain();
    chk(acc_cnt == a0, "R9 no access", 32'(acc_cnt - a0), 32'd0);

    // R10 stray bytes and restart on a new start marker
    cur_tag = "R10";
    send_raw(8'h10, 1'b0, 1'b0);
    send_raw(8'h22, 1'b0, 1'b1);
    repeat (10) @(negedge clk_i);
    chk(acc_cnt == a0, "R10 stray bytes ignored", 32'(acc_cnt - a0), 32'd0);
    send_raw(8'h00, 1'b1, 1'b0);
    send_raw(8'h00, 1'b0, 1'b0);
    exp_word(ref_m[17], 1'b1, 1'b1, "R10 restarted packet");
    hdr(8'h10, 16'd4, 32'h0000_0044);
    send_pkt();
    drain();
    chk(acc_cnt == a0 + 1, "R10 single access after restart", 32'(acc_cnt - a0), 32'd1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk_i);
        chk(1'b0, "R11 watchdog expired", 32'd0, 32'd1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule